// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver

This block turns an asynchronous serial line into bytes. The line is brought through a two-stage synchronizer. It is then examined only on cycles where a one-cycle enable pulse is high. That enable runs at a fixed multiple of the bit rate (16 by default) and is produced elsewhere in the system clock domain. A falling edge on the idle-high line opens a candidate frame. The candidate is kept only if the line is still low half a bit later. After that, each data bit is taken once at its centre, least significant bit first, and the closing stop bits are then checked.

A finished byte goes into an output register and raises a ready flag. A single-cycle read strobe lowers that flag. The output register is separate from the shift register, so a byte that has been delivered stays put while the next character is being shifted in. Three sticky flags report problems. Overrun means a byte arrived while the previous one was still unread. Underrun means a stop bit was low after a frame that carried some high data bit. All-low means a stop bit was low after a frame whose data bits were all low. Surrounding logic may feed these flags back into the reset input to restart the receiver.

Top module: `serial_rx_core`

## Requirements
- R1: A synchronous active-high reset returns the receiver to idle and clears the ready flag, all three error flags and the byte output to zero.
- R2: A low level on the line starts a frame only if it is still low at the sample taken OVERSAMPLE/2 enables after the enable that first saw it low. A shorter low pulse produces no ready flag and no error.
- R3: The line is sampled only on cycles where the enable input is high. Each data bit is taken once every OVERSAMPLE enables. The first received data bit lands in bit 0 of the byte output.
- R4: When every stop bit samples high, the ready flag and the new byte appear together in the cycle after the last stop sample.
- R5: A read pulse while ready is high clears ready on the next cycle, unless a new byte completes in that same cycle.
- R6: The byte output changes only when a byte completes. It stays unchanged while the following character is being shifted in.
- R7: If a byte completes while ready is still high and no read is given, the overrun flag sets, the new byte replaces the output and ready stays high.
- R8: A stop bit sampled low, when at least one data bit of that frame was high, sets the underrun flag. Ready stays low and the byte output keeps its previous value.
- R9: A stop bit sampled low, when every data bit of that frame was low, sets the all-low flag and leaves the underrun flag clear.
- R10: Once set, each error flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle enable pulse at OVERSAMPLE times the bit rate |
| line_i | input | 1 | Asynchronous serial input, high when idle |
| read_i | input | 1 | Read strobe that clears the ready flag |
| data_o | output | DATA_BITS | Last complete byte received |
| ready_o | output | 1 | A byte is waiting to be read |
| overrun_o | output | 1 | Sticky: a byte arrived while the previous one was unread |
| underrun_o | output | 1 | Sticky: stop bit low after a frame with some high data bit |
| all_low_o | output | 1 | Sticky: stop bit low after a frame whose data bits were all low |

## Verification
Several rules are checked on every cycle by properties that watch the completion and stop-failure events coming out of the framing logic:
- ready rises only after a completion;
- a read lowers ready;
- the byte output holds between completions;
- events occur only on enable cycles;
- each error flag rises only for its own cause and then stays set.

Other behaviour depends on where the line edges fall relative to the enable pulses, so only the bench scenarios can show it. That covers the bit order, the rejection of a short low glitch, telling underrun from all-low by the frame contents, and a held byte surviving a second arrival.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  // Number of enables between the first low sample and the start-bit centre.
  function automatic int unsigned rx_half_count(input int unsigned oversample);
    return oversample / 2;
  endfunction

  // Widest of the three bit counts, used to size the bit counter.
  function automatic int unsigned rx_max3(input int unsigned a, input int unsigned b,
                                          input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) chain_q <= '1;
    else       chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/serial_rx_timer.sv
module serial_rx_timer #(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tick_i,
  input  logic restart_i,
  output logic mid_o,
  output logic full_o
);
  import serial_rx_pkg::*;

  localparam int unsigned CW   = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
  localparam int unsigned HALF = rx_half_count(OVERSAMPLE);

  logic [CW-1:0] cnt_q;

  assign mid_o  = tick_i && (cnt_q == CW'(HALF - 1));
  assign full_o = tick_i && (cnt_q == CW'(OVERSAMPLE - 1));

  always_ff @(posedge clk_i) begin
    if (rst_i)          cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= full_o ? '0 : cnt_q + CW'(1);
  end

endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer #(
  parameter int unsigned START_BITS = 1,
  parameter int unsigned DATA_BITS  = 8,
  parameter int unsigned STOP_BITS  = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 tick_i,
  input  logic                 line_i,
  input  logic                 mid_i,
  input  logic                 full_i,
  output logic                 restart_o,
  output logic                 word_done_o,
  output logic                 stop_fail_o,
  output logic [DATA_BITS-1:0] word_o
);
  import serial_rx_pkg::*;

  localparam int unsigned MAXB = rx_max3(START_BITS, DATA_BITS, STOP_BITS);
  localparam int unsigned BW   = $clog2(MAXB + 1);

  rx_state_e            state_q;
  logic [BW-1:0]        bit_q;
  logic [DATA_BITS-1:0] shift_q;

  logic start_seen, first_start, start_smp, data_smp, stop_smp;
  logic last_start, last_data, last_stop;

  assign first_start = (state_q == RX_START) && (bit_q == '0);
  assign start_seen  = (state_q == RX_IDLE) && tick_i && !line_i;
  assign start_smp   = (state_q == RX_START) && (first_start ? mid_i : full_i);
  assign data_smp    = (state_q == RX_DATA) && full_i;
  assign stop_smp    = (state_q == RX_STOP) && full_i;

  assign last_start  = (bit_q == BW'(START_BITS - 1));
  assign last_data   = (bit_q == BW'(DATA_BITS - 1));
  assign last_stop   = (bit_q == BW'(STOP_BITS - 1));

  assign restart_o   = start_seen || (first_start && mid_i && !line_i);
  assign word_done_o = stop_smp && line_i && last_stop;
  assign stop_fail_o = stop_smp && !line_i;
  assign word_o      = shift_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= RX_IDLE;
      bit_q   <= '0;
      shift_q <= '0;
    end else begin
      unique case (state_q)
        RX_IDLE: begin
          if (start_seen) begin
            state_q <= RX_START;
            bit_q   <= '0;
          end
        end
        RX_START: begin
          if (start_smp) begin
            if (line_i) begin
              state_q <= RX_IDLE;
              bit_q   <= '0;
            end else if (last_start) begin
              state_q <= RX_DATA;
              bit_q   <= '0;
            end else begin
              bit_q <= bit_q + BW'(1);
            end
          end
        end
        RX_DATA: begin
          if (data_smp) begin
            shift_q <= (shift_q >> 1) | (DATA_BITS'(line_i) << (DATA_BITS - 1));
            if (last_data) begin
              state_q <= RX_STOP;
              bit_q   <= '0;
            end else begin
              bit_q <= bit_q + BW'(1);
            end
          end
        end
        RX_STOP: begin
          if (stop_smp) begin
            if (!line_i || last_stop) begin
              state_q <= RX_IDLE;
              bit_q   <= '0;
            end else begin
              bit_q <= bit_q + BW'(1);
            end
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/serial_rx_outreg.sv
module serial_rx_outreg #(
  parameter int unsigned DATA_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 word_done_i,
  input  logic                 stop_fail_i,
  input  logic [DATA_BITS-1:0] word_i,
  input  logic                 read_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 ready_o,
  output logic                 overrun_o,
  output logic                 underrun_o,
  output logic                 all_low_o
);

  logic any_high;
  assign any_high = |word_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      data_o     <= '0;
      ready_o    <= 1'b0;
      overrun_o  <= 1'b0;
      underrun_o <= 1'b0;
      all_low_o  <= 1'b0;
    end else begin
      if (word_done_i) begin
        data_o  <= word_i;
        ready_o <= 1'b1;
        if (ready_o && !read_i) overrun_o <= 1'b1;
      end else if (read_i) begin
        ready_o <= 1'b0;
      end
      if (stop_fail_i) begin
        if (any_high) underrun_o <= 1'b1;
        else          all_low_o  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
  parameter int unsigned START_BITS = 1,
  parameter int unsigned DATA_BITS  = 8,
  parameter int unsigned STOP_BITS  = 1,
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 tick_i,
  input  logic                 line_i,
  input  logic                 read_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 ready_o,
  output logic                 overrun_o,
  output logic                 underrun_o,
  output logic                 all_low_o
);

  logic                 line_s;
  logic                 mid_evt, full_evt, restart;
  logic                 word_done, stop_fail;
  logic [DATA_BITS-1:0] word;

  serial_rx_sync #(.STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .async_i(line_i),
    .sync_o (line_s)
  );

  serial_rx_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .tick_i   (tick_i),
    .restart_i(restart),
    .mid_o    (mid_evt),
    .full_o   (full_evt)
  );

  serial_rx_framer #(
    .START_BITS(START_BITS),
    .DATA_BITS (DATA_BITS),
    .STOP_BITS (STOP_BITS)
  ) u_framer (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .tick_i     (tick_i),
    .line_i     (line_s),
    .mid_i      (mid_evt),
    .full_i     (full_evt),
    .restart_o  (restart),
    .word_done_o(word_done),
    .stop_fail_o(stop_fail),
    .word_o     (word)
  );

  serial_rx_outreg #(.DATA_BITS(DATA_BITS)) u_out (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .word_done_i(word_done),
    .stop_fail_i(stop_fail),
    .word_i     (word),
    .read_i     (read_i),
    .data_o     (data_o),
    .ready_o    (ready_o),
    .overrun_o  (overrun_o),
    .underrun_o (underrun_o),
    .all_low_o  (all_low_o)
  );

endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk #(
  parameter int unsigned DATA_BITS = 8
) (
  input logic                 clk_i,
  input logic                 rst_i,
  input logic                 tick_i,
  input logic                 read_i,
  input logic                 word_done,
  input logic                 stop_fail,
  input logic [DATA_BITS-1:0] data_o,
  input logic                 ready_o,
  input logic                 overrun_o,
  input logic                 underrun_o,
  input logic                 all_low_o
);

  assert_sample_on_tick_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (word_done || stop_fail) |-> tick_i);

  assert_ready_source_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(ready_o) |-> $past(word_done));

  assert_read_clears_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (ready_o && read_i && !word_done) |=> !ready_o);

  assert_hold_byte_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !word_done |=> $stable(data_o));

  assert_overrun_cause_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(overrun_o) |-> $past(word_done && ready_o && !read_i));

  assert_underrun_cause_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(underrun_o) |-> $past(stop_fail));

  assert_all_low_cause_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(all_low_o) |-> $past(stop_fail));

  assert_sticky_flags_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (overrun_o || underrun_o || all_low_o) |=>
      ((overrun_o || !$past(overrun_o)) && (underrun_o || !$past(underrun_o)) &&
       (all_low_o || !$past(all_low_o))));

endmodule

bind serial_rx_core serial_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .tick_i    (tick_i),
  .read_i    (read_i),
  .word_done (word_done),
  .stop_fail (stop_fail),
  .data_o    (data_o),
  .ready_o   (ready_o),
  .overrun_o (overrun_o),
  .underrun_o(underrun_o),
  .all_low_o (all_low_o)
);

// File: tb/serial_rx_core_tb.sv
`timescale 1ns/1ps
module serial_rx_core_tb;

  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       line = 1'b1;
  logic       auto_pulse = 1'b0;
  logic       man_rd = 1'b0;
  logic       read;
  logic [7:0] data;
  logic       ready, ovr, und, alow;

  int  checks = 0;
  int  errors = 0;
  bit  auto_read = 1'b0;
  bit  done = 1'b0;
  int  div = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  assign read = auto_pulse | man_rd;

  serial_rx_core u_dut (
    .clk_i     (clk),
    .rst_i     (rst),
    .tick_i    (tick),
    .line_i    (line),
    .read_i    (read),
    .data_o    (data),
    .ready_o   (ready),
    .overrun_o (ovr),
    .underrun_o(und),
    .all_low_o (alow)
  );

  always @(negedge clk) begin
    div  <= (div == TICK_DIV - 1) ? 0 : div + 1;
    tick <= (div == TICK_DIV - 1);
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // Monitor: pops the expected byte and compares when ready is seen.
  always @(negedge clk) begin
    auto_pulse <= 1'b0;
    if (!rst && auto_read && ready && !auto_pulse) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected byte", int'(data), 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(data == e, "R3/R4 byte value", int'(data), int'(e));
      end
      auto_pulse <= 1'b1;
    end
  end

  task automatic send_frame(input logic [7:0] d, input logic stopv);
    line = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      line = d[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
    line = stopv;
    repeat (BIT_CLKS) @(negedge clk);
    line = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic push_send(input logic [7:0] d);
    exp_q.push_back(d);
    send_frame(d, 1'b1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic manual_read();
    man_rd = 1'b1;
    @(negedge clk);
    man_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(ready == 1'b0 && ovr == 1'b0 && und == 1'b0 && alow == 1'b0, "R1 flags after reset",
          {ready, ovr, und, alow}, 0);
    check(data == 8'h00, "R1 byte after reset", int'(data), 0);

    // R3/R4/R5: scoreboard stream with automatic reads
    auto_read = 1'b1;
    push_send(8'h55);
    push_send(8'hA3);
    push_send(8'h00);
    push_send(8'hFF);
    push_send(8'h80);
    push_send(8'h01);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R4 all bytes delivered", exp_q.size(), 0);
    check(ready == 1'b0, "R5 ready cleared by read", int'(ready), 0);
    check(ovr == 1'b0 && und == 1'b0 && alow == 1'b0, "R4 no error in clean stream",
          {ovr, und, alow}, 0);
    auto_read = 1'b0;

    // R2: short low glitch ignored
    line = 1'b0;
    repeat (5 * TICK_DIV) @(negedge clk);
    line = 1'b1;
    repeat (12 * BIT_CLKS) @(negedge clk);
    check(ready == 1'b0, "R2 glitch gives no byte", int'(ready), 0);
    check({ovr, und, alow} == 3'b000, "R2 glitch gives no error", {ovr, und, alow}, 0);
    check(data == 8'h01, "R2 byte output untouched", int'(data), 8'h01);

    // R6/R7: held byte survives next arrival, then overrun
    send_frame(8'h3C, 1'b1);
    check(ready == 1'b1 && data == 8'h3C, "R4 byte waiting", int'(data), 8'h3C);
    fork
      send_frame(8'hC5, 1'b1);
      begin
        repeat (5 * BIT_CLKS) @(negedge clk);
        check(data == 8'h3C, "R6 byte held during next frame", int'(data), 8'h3C);
        check(ovr == 1'b0, "R7 no overrun before completion", int'(ovr), 0);
      end
    join
    check(ovr == 1'b1, "R7 overrun set", int'(ovr), 1);
    check(data == 8'hC5, "R7 new byte replaces output", int'(data), 8'hC5);
    check(ready == 1'b1, "R7 ready stays high", int'(ready), 1);
    manual_read();
    check(ready == 1'b0, "R5 manual read clears ready", int'(ready), 0);
    check(ovr == 1'b1, "R10 overrun sticky after read", int'(ovr), 1);
    do_reset();
    check({ready, ovr, und, alow} == 4'b0000 && data == 8'h00, "R1 reset clears overrun",
          {ready, ovr, und, alow}, 0);

    // R8: underrun on bad stop with data
    send_frame(8'h5A, 1'b0);
    repeat (BIT_CLKS) @(negedge clk);
    check(und == 1'b1, "R8 underrun set", int'(und), 1);
    check(alow == 1'b0, "R8 all-low clear", int'(alow), 0);
    check(ready == 1'b0 && data == 8'h00, "R8 no byte delivered", int'(data), 0);
    repeat (4 * BIT_CLKS) @(negedge clk);
    check(und == 1'b1, "R10 underrun sticky", int'(und), 1);
    do_reset();
    check(und == 1'b0, "R1 reset clears underrun", int'(und), 0);

    // R9: line stuck low for a whole frame
    line = 1'b0;
    repeat (9 * BIT_CLKS + 48) @(negedge clk);
    line = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    check(alow == 1'b1, "R9 all-low set", int'(alow), 1);
    check(und == 1'b0, "R9 underrun clear", int'(und), 0);
    check(ready == 1'b0, "R9 no byte delivered", int'(ready), 0);
    repeat (2 * BIT_CLKS) @(negedge clk);
    check(alow == 1'b1, "R10 all-low sticky", int'(alow), 1);

    finish_run();
  end

endmodule